// File: doc/BRIEF.md
# Watchdog Timer with Reset Generation

This block is a supervision timer for a processor subsystem. A 15-bit counter steps forward at a slow rate taken from a prescaler. The prescaler produces one step every 24 or every 384 clocks, and a select input chooses the rate. If software does not refresh the counter before it reaches the fixed terminal count 7CFFh, the block raises a one-cycle reset request for the rest of the chip. It also sets a sticky flag, so that code running after the forced reset can tell that the watchdog caused it.

The watchdog comes out of an external reset disabled, with every register at zero. It can be armed in two ways. A start pin that is high while the external reset is applied arms it in hardware. Otherwise, a software write with the enable value 1 arms it. Once armed, it stays armed: a write with the enable value 0 is ignored, and its own timeout does not disarm it. Only the external reset disarms it. The register decoding that turns bus writes into the strobes used here sits outside this block.

Top module: `wdog_core`

## Requirements
- R1: When `ext_rst` is released with `start_pin` low, `wdt_rst_req` and `wdt_flag` read 0. With no enable write, no reset request ever follows, whatever is applied to `kick`.
- R2: If `start_pin` is high while `ext_rst` is applied, counting starts at once. The first reset request is high in the cycle after rising edge TERMINAL·DIV+1, where edges are counted from the last edge at which `ext_rst` was sampled high.
- R3: DIV is FAST_DIV (24 by default) when `rate_sel` = 0 and SLOW_DIV (384 by default) when `rate_sel` = 1. One counter step occurs per DIV clocks.
- R4: A write with `en_wr` = 1 and `en_val` = 1 arms the watchdog. The first reset request follows TERMINAL·DIV+1 edges after the edge that sampled the write.
- R5: While the watchdog is armed, a write with `en_val` = 0 has no effect and the timeout still occurs on schedule. Only `ext_rst` disarms it.
- R6: When the count equals TERMINAL (7CFFh by default), the next edge raises `wdt_rst_req` for exactly one cycle and sets `wdt_flag`.
- R7: A `kick` sampled at an edge at or before the edge where the count reaches TERMINAL clears both the counter and the prescaler to zero. The next timeout then follows TERMINAL·DIV+1 edges after the `kick` edge.
- R8: A `kick` sampled at the same edge that acts on a count already equal to TERMINAL does not prevent the timeout.
- R9: After a timeout the counter and the prescaler restart from zero and the watchdog stays armed. The next request follows TERMINAL·DIV+1 edges later.
- R10: `wdt_flag` is kept through the watchdog's own reset request. It is cleared by `flag_clr` or by `ext_rst`. If a timeout and `flag_clr` fall on the same edge, the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| ext_rst | input | 1 | Synchronous external reset, active high |
| start_pin | input | 1 | Arms the watchdog when high during `ext_rst` |
| en_wr | input | 1 | One-cycle strobe writing the enable value |
| en_val | input | 1 | Enable value carried by `en_wr`; only 1 has an effect |
| kick | input | 1 | One-cycle refresh strobe |
| rate_sel | input | 1 | 0: step every FAST_DIV clocks, 1: every SLOW_DIV clocks |
| flag_clr | input | 1 | One-cycle strobe clearing the timeout flag |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |
| wdt_flag | output | 1 | Sticky record of a watchdog-caused reset |

## Verification
The embedded properties guard, on every cycle, the invariants the design must never break:
- the count never passes the terminal value;
- the prescaler stays below its slow divisor;
- a disarmed watchdog holds a zero count;
- the request is one cycle wide and is always accompanied by the flag;
- the armed state never drops without the external reset;
- a refresh or a timeout leaves both counters at zero.

Only the bench scenarios can show the exact edge on which a timeout lands. The bench sweeps both rates, both ways of arming, and every refresh position up to and one past the terminal edge. It also covers the enable-zero write and the flag clear/set collision, each of which has an effect, or none, only over a whole timeout window.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

    typedef enum logic {
        RATE_FAST = 1'b0,
        RATE_SLOW = 1'b1
    } rate_e;

    typedef struct packed {
        logic armed;
        logic flag;
    } wdog_ctl_t;

endpackage

// File: rtl/wdog_prescaler.sv
`timescale 1ns/1ps
module wdog_prescaler #(
    parameter int FAST_DIV = 24,
    parameter int SLOW_DIV = 384
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    input  logic rate_sel,
    output logic tick
);
    import wdog_pkg::*;

    localparam int PW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PW-1:0] LIM_FAST = PW'(FAST_DIV - 1);
    localparam logic [PW-1:0] LIM_SLOW = PW'(SLOW_DIV - 1);

    logic [PW-1:0] pre_d, pre_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit = (rate_e'(rate_sel) == RATE_SLOW) ? LIM_SLOW : LIM_FAST;
        tick  = run && (pre_q >= limit);
        pre_d = pre_q;
        if (rst || clear) begin
            pre_d = '0;
        end else if (run) begin
            pre_d = tick ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        pre_q <= pre_d;
    end

    // R3: the divider never runs past the slow divisor
    a_r3_pre_bounded: assert property (@(posedge clk) disable iff (rst)
        pre_q <= LIM_SLOW);

    // R7: refresh or timeout restarts the divider from zero
    a_r7_pre_cleared: assert property (@(posedge clk) disable iff (rst)
        clear |=> (pre_q == '0));

endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
    parameter int              CNT_W    = 15,
    parameter logic [CNT_W-1:0] TERMINAL = 15'h7CFF
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic refresh,
    output logic hit,
    output logic expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        hit        = run && (st_q.cnt == TERMINAL);
        st_d       = st_q;
        st_d.req   = 1'b0;
        if (rst) begin
            st_d = '0;
        end else if (hit) begin
            st_d.cnt = '0;
            st_d.req = 1'b1;
        end else if (refresh) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign expire = st_q.req;

    // R6: the count stops at the terminal value
    a_r6_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= TERMINAL);

    // R6: the reset request lasts a single cycle
    a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
        st_q.req |=> !st_q.req);

    // R9: the counter is back at zero when the request is raised
    a_r9_req_zero: assert property (@(posedge clk) disable iff (rst)
        st_q.req |-> (st_q.cnt == '0));

    // R1: a disarmed watchdog holds a zero count
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !run |-> (st_q.cnt == '0));

    // R7: a refresh before the terminal count clears the counter
    a_r7_refresh_zero: assert property (@(posedge clk) disable iff (rst)
        (refresh && !hit) |=> (st_q.cnt == '0));

endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/1ps
module wdog_core #(
    parameter int              CNT_W    = 15,
    parameter logic [CNT_W-1:0] TERMINAL = 15'h7CFF,
    parameter int              FAST_DIV = 24,
    parameter int              SLOW_DIV = 384
) (
    input  logic clk,
    input  logic ext_rst,
    input  logic start_pin,
    input  logic en_wr,
    input  logic en_val,
    input  logic kick,
    input  logic rate_sel,
    input  logic flag_clr,
    output logic wdt_rst_req,
    output logic wdt_flag
);
    import wdog_pkg::*;

    wdog_ctl_t ctl_d, ctl_q;
    logic      tick;
    logic      hit;
    logic      pre_clear;
    logic      kick_eff;

    always_comb begin
        ctl_d = ctl_q;
        if (ext_rst) begin
            ctl_d.armed = start_pin;
            ctl_d.flag  = 1'b0;
        end else begin
            ctl_d.armed = ctl_q.armed | (en_wr & en_val);
            if (hit) begin
                ctl_d.flag = 1'b1;
            end else if (flag_clr) begin
                ctl_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign kick_eff  = kick & ctl_q.armed;
    assign pre_clear = kick_eff | hit;

    wdog_prescaler #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_pre (
        .clk      (clk),
        .rst      (ext_rst),
        .run      (ctl_q.armed),
        .clear    (pre_clear),
        .rate_sel (rate_sel),
        .tick     (tick)
    );

    wdog_counter #(
        .CNT_W    (CNT_W),
        .TERMINAL (TERMINAL)
    ) u_cnt (
        .clk     (clk),
        .rst     (ext_rst),
        .run     (ctl_q.armed),
        .tick    (tick),
        .refresh (kick_eff),
        .hit     (hit),
        .expire  (wdt_rst_req)
    );

    assign wdt_flag = ctl_q.flag;

    // R5: once armed, only the external reset disarms
    a_r5_stay_armed: assert property (@(posedge clk) disable iff (ext_rst)
        ctl_q.armed |=> ctl_q.armed);

    // R10: every reset request is accompanied by the flag
    a_r10_req_flag: assert property (@(posedge clk) disable iff (ext_rst)
        wdt_rst_req |-> wdt_flag);

    // R6: the flag only rises together with a request
    a_r6_flag_cause: assert property (@(posedge clk) disable iff (ext_rst)
        $rose(wdt_flag) |-> wdt_rst_req);

endmodule

// File: tb/tb_wdog_core.sv
`timescale 1ns/1ps
module tb_wdog_core;

    localparam int T  = 5;
    localparam int FD = 3;
    localparam int SD = 7;

    logic clk = 1'b0;
    logic ext_rst = 1'b1, start_pin = 1'b0, en_wr = 1'b0, en_val = 1'b0;
    logic kick = 1'b0, rate_sel = 1'b0, flag_clr = 1'b0;
    logic wdt_rst_req, wdt_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wdog_core #(
        .CNT_W    (15),
        .TERMINAL (15'd5),
        .FAST_DIV (FD),
        .SLOW_DIV (SD)
    ) dut (
        .clk (clk), .ext_rst (ext_rst), .start_pin (start_pin),
        .en_wr (en_wr), .en_val (en_val), .kick (kick),
        .rate_sel (rate_sel), .flag_clr (flag_clr),
        .wdt_rst_req (wdt_rst_req), .wdt_flag (wdt_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic sp, input logic rs);
        ext_rst = 1'b1; start_pin = sp; rate_sel = rs;
        en_wr = 1'b0; en_val = 1'b0; kick = 1'b0; flag_clr = 1'b0;
        repeat (3) edge_step();
        ext_rst = 1'b0; start_pin = 1'b0;
    endtask

    // runs edges 1..limit; returns the first edge index after which a request is seen
    task automatic run_seq(input int kick_at, input int off_at, input int clr_at,
                           input int limit, output int at);
        at = -1;
        for (int i = 1; i <= limit; i++) begin
            kick = (i == kick_at);
            en_wr = (i == off_at); en_val = 1'b0;
            flag_clr = (i == clr_at);
            edge_step();
            kick = 1'b0; en_wr = 1'b0; flag_clr = 1'b0;
            if (wdt_rst_req) begin
                at = i;
                break;
            end
        end
    endtask

    initial begin
        int at;
        int div;
        int p;
        int exp;
        // R1: reset state and no activity while disarmed
        do_reset(1'b0, 1'b0);
        check(wdt_rst_req == 1'b0, "R1 req after reset", int'(wdt_rst_req), 0);
        check(wdt_flag == 1'b0, "R1 flag after reset", int'(wdt_flag), 0);
        run_seq(4, 0, 0, 200, at);
        check(at == -1, "R1 no request while disarmed", at, -1);

        for (int r = 0; r < 2; r++) begin
            div = (r == 0) ? FD : SD;
            p = T * div + 1;

            // R2/R3/R5: pin start, enable-zero write ignored
            do_reset(1'b1, 1'(r));
            run_seq(0, 2, 0, p + 5, at);
            check(at == p, "R2 R3 R5 first timeout edge", at, p);
            check(wdt_flag == 1'b1, "R6 flag set", int'(wdt_flag), 1);
            edge_step();
            check(wdt_rst_req == 1'b0, "R6 request one cycle", int'(wdt_rst_req), 0);
            // R9: restart from zero, still armed (one edge already consumed)
            run_seq(0, 0, 0, p + 5, at);
            check(at == p - 1, "R9 second timeout edge", at, p - 1);
            check(wdt_flag == 1'b1, "R10 flag kept", int'(wdt_flag), 1);
            // R10/R5: external reset clears flag and disarms
            do_reset(1'b0, 1'(r));
            check(wdt_flag == 1'b0, "R10 flag cleared by ext reset", int'(wdt_flag), 0);
            run_seq(0, 0, 0, p + 5, at);
            check(at == -1, "R5 disarmed by ext reset", at, -1);

            // R4: software start
            do_reset(1'b0, 1'(r));
            en_wr = 1'b1; en_val = 1'b1;
            edge_step();
            en_wr = 1'b0; en_val = 1'b0;
            run_seq(0, 0, 0, p + 5, at);
            check(at == p, "R4 software start timeout edge", at, p);
            flag_clr = 1'b1;
            edge_step();
            flag_clr = 1'b0;
            check(wdt_flag == 1'b0, "R10 flag_clr clears", int'(wdt_flag), 0);

            // R10: set wins over clear on the timeout edge
            do_reset(1'b1, 1'(r));
            run_seq(0, 0, p, p + 5, at);
            check(at == p, "R10 collision timeout edge", at, p);
            check(wdt_flag == 1'b1, "R10 set wins over clear", int'(wdt_flag), 1);

            // R7/R8: refresh sweep over every edge up to one past the terminal edge
            for (int k = 1; k <= p; k++) begin
                do_reset(1'b1, 1'(r));
                run_seq(k, 0, 0, k + p + 5, at);
                exp = (k <= p - 1) ? k + p : p;
                if (k <= p - 1)
                    check(at == exp, "R7 refresh delays timeout", at, exp);
                else
                    check(at == exp, "R8 late refresh ignored", at, exp);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0 (run hung)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule